// File: doc/BRIEF.md
# Two-Phase Circular Trace Capture Controller

This block steers writes into an on-chip trace buffer that is captured in two phases. Capture opens in a pre-trigger phase. In that phase, writes cycle through a circular window at the start of the buffer. The size of that window comes from a trigger-placement setting. When a trigger arrives, the controller moves to a post-trigger phase. It then places a fixed number of further writes after the current pointer and stops on its own once they are stored. The traced processor is never stalled. Only the buffer stops taking data.

Each accepted request writes one 64-bit word, so the address advances by 8 bytes per write. The buffer size is set in whole kilobytes, or 128 words per unit. A sticky wrap flag tells a later reader whether the pre-trigger window was overwritten, and so where the oldest valid entry sits. A synchronous restart input starts a new capture without a full reset.

Top module: `trace_capture_ctl`

## Requirements
- R1: After reset or restart, `phase` is 0 (pre-trigger), `done` is 0, `wrapped` is 0, and `wr_addr` equals the aligned base address.
- R2: In the pre-trigger phase, each `wr_req` gives `wr_en`=1 at address base + 8·p, where p counts 0,1,…,W−1 and then returns to 0. W is the window size in words. `cfg_pos` code 1 gives W = 64·`cfg_size_kb`. Codes 2 and 3 both give W = 128·`cfg_size_kb`.
- R3: With `cfg_pos` code 0, W is 0. Pre-trigger requests are dropped, with `wr_en`=0.
- R4: `wrapped` becomes 1 on the edge after a pre-trigger write to slot W−1. It stays at 1 until restart or reset.
- R5: A `trig` seen in the pre-trigger phase sets `phase` to 1 on the next edge. A write in the same cycle as the trigger is stored as a pre-trigger write.
- R6: In the post-trigger phase, writes continue from the current pointer without wrapping. Exactly 128·`cfg_size_kb` − W writes are stored. After that, `done` is 1 and `wr_en` stays 0. When that count is zero, `done` rises on the edge that takes the trigger.
- R7: A `trig` in the post-trigger phase or after `done` has no effect.
- R8: Bits [2:0] of `cfg_base` are ignored. `wr_addr[2:0]` is always 0.
- R9: `restart` wins over every other input. In its cycle `wr_en` is 0. On the next edge the controller is back in the pre-trigger phase at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous capture restart |
| cfg_base | input | ADDR_W | Buffer start byte address (low 3 bits ignored) |
| cfg_size_kb | input | SIZE_W | Buffer size in kilobytes |
| cfg_pos | input | 2 | Trigger placement: 0 begin, 1 center, 2/3 end |
| wr_req | input | 1 | One 64-bit trace word is ready |
| trig | input | 1 | Trigger event |
| wr_en | output | 1 | Store the word at `wr_addr` this cycle |
| wr_addr | output | ADDR_W | Byte address of the current slot |
| phase | output | 1 | 0 pre-trigger, 1 post-trigger |
| done | output | 1 | Post-trigger space is full |
| wrapped | output | 1 | Pre-trigger window has overwritten itself |

## Verification
The bench drives the pointer across the last slot of the window in center, end and double-size settings. An off-by-one wrap would show up there as a write beyond the window, or as the wrap flag rising one write early or late. It counts post-trigger writes from a pointer that is not zero, so a design that counts from the base, or stops one word early or late, stores a wrong total. End placement must finish on the trigger edge with zero post writes, and begin placement must drop pre-trigger data. A design that mishandles the empty window would either write during the pre-trigger phase or hang in the post-trigger phase. Late triggers, a restart in the middle of the post-trigger phase, and a misaligned base round out the cases that a careless priority or address mask would get wrong.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_POST = 2'd1,
    ST_DONE = 2'd2
  } tbc_state_e;

  typedef enum logic [1:0] {
    POS_BEGIN  = 2'd0,
    POS_CENTER = 2'd1,
    POS_END    = 2'd2,
    POS_END2   = 2'd3
  } tbc_pos_e;

  localparam int unsigned WORD_SHIFT   = 3;  // 8-byte words
  localparam int unsigned KB_WORDS_LOG = 7;  // 128 words per kilobyte

endpackage

// File: rtl/tbc_geometry.sv
module tbc_geometry
  import tbc_pkg::*;
#(
  parameter int unsigned SIZE_W = 4,
  localparam int unsigned CNT_W = SIZE_W + KB_WORDS_LOG
) (
  input  logic [SIZE_W-1:0] size_kb,
  input  logic [1:0]        pos,
  output logic [CNT_W-1:0]  total_words,
  output logic [CNT_W-1:0]  win_words,
  output logic [CNT_W-1:0]  post_words
);

  always_comb begin
    total_words = {size_kb, {KB_WORDS_LOG{1'b0}}};
    unique case (tbc_pos_e'(pos))
      POS_BEGIN:  win_words = '0;
      POS_CENTER: win_words = total_words >> 1;
      default:    win_words = total_words;
    endcase
    post_words = total_words - win_words;
  end

endmodule

// File: rtl/tbc_pointer.sv
module tbc_pointer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             in_pre,
  input  logic [CNT_W-1:0] win_words,
  output logic [CNT_W-1:0] ptr,
  output logic             wrapped
);

  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic             wrap_q, wrap_d;
  logic             last_slot;

  assign last_slot = (ptr_q == win_words - 1'b1);

  always_comb begin
    ptr_d  = ptr_q;
    wrap_d = wrap_q;
    if (clr) begin
      ptr_d  = '0;
      wrap_d = 1'b0;
    end else if (adv) begin
      if (in_pre && last_slot) begin
        ptr_d  = '0;
        wrap_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      wrap_q <= wrap_d;
    end
  end

  assign ptr     = ptr_q;
  assign wrapped = wrap_q;

  // R2: pre-trigger writes land inside the window
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pre && adv && !clr) |-> (ptr_q < win_words));

  // R4: wrap flag is sticky until clear
  a_r4_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !clr) |=> wrap_q);

endmodule

// File: rtl/tbc_phase_ctl.sv
module tbc_phase_ctl
  import tbc_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             trig,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] win_words,
  input  logic [CNT_W-1:0] post_words,
  output tbc_state_e       state,
  output logic             store
);

  tbc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    store   = 1'b0;
    if (restart) begin
      state_d = ST_PRE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_PRE: begin
          store = wr_req && (win_words != '0);
          if (trig) begin
            cnt_d   = '0;
            state_d = (post_words == '0) ? ST_DONE : ST_POST;
          end
        end
        ST_POST: begin
          store = wr_req;
          if (wr_req) begin
            cnt_d = cnt_inc;
            if (cnt_inc == post_words) state_d = ST_DONE;
          end
        end
        default: begin
          store = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PRE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

  // R5: a pre-phase trigger leaves the pre phase on the next edge
  a_r5_trig_leaves_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && trig && !restart) |=> (state_q != ST_PRE));

  // R7: without restart the controller never falls back to pre phase
  a_r7_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PRE && !restart) |=> (state_q != ST_PRE));

  // R6: post-phase count stays below the post-trigger length
  a_r6_post_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POST) |-> (cnt_q < post_words));

endmodule

// File: rtl/trace_capture_ctl.sv
module trace_capture_ctl
  import tbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size_kb,
  input  logic [1:0]        cfg_pos,
  input  logic              wr_req,
  input  logic              trig,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              phase,
  output logic              done,
  output logic              wrapped
);

  localparam int unsigned CNT_W  = SIZE_W + KB_WORDS_LOG;
  localparam int unsigned WIDX_W = ADDR_W - WORD_SHIFT;

  logic [CNT_W-1:0]  total_words, win_words, post_words;
  logic [CNT_W-1:0]  ptr;
  logic [WIDX_W-1:0] word_idx;
  tbc_state_e        state;
  logic              store;

  tbc_geometry #(.SIZE_W(SIZE_W)) u_geom (
    .size_kb     (cfg_size_kb),
    .pos         (cfg_pos),
    .total_words (total_words),
    .win_words   (win_words),
    .post_words  (post_words)
  );

  tbc_phase_ctl #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .trig       (trig),
    .wr_req     (wr_req),
    .win_words  (win_words),
    .post_words (post_words),
    .state      (state),
    .store      (store)
  );

  tbc_pointer #(.CNT_W(CNT_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (restart),
    .adv       (store),
    .in_pre    (state == ST_PRE),
    .win_words (win_words),
    .ptr       (ptr),
    .wrapped   (wrapped)
  );

  assign word_idx = cfg_base[ADDR_W-1:WORD_SHIFT] + {{(WIDX_W-CNT_W){1'b0}}, ptr};
  assign wr_addr  = {word_idx, {WORD_SHIFT{1'b0}}};
  assign wr_en    = store;
  assign phase    = (state != ST_PRE);
  assign done     = (state == ST_DONE);

  // R8: addresses are word aligned
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr[WORD_SHIFT-1:0] == '0);

  // R6: nothing is written once capture is finished
  a_r6_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R9: restart returns to a clean pre-trigger state
  a_r9_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!phase && !done && !wrapped));

  // R3: empty window drops pre-trigger data
  a_r3_begin_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && cfg_pos == 2'd0) |-> !wr_en);

endmodule

// File: tb/trace_capture_ctl_test.sv
`timescale 1ns/1ps
module trace_capture_ctl_test;

  localparam int ADDR_W = 32;
  localparam int SIZE_W = 4;
  localparam logic [31:0] BASE_RAW = 32'h1000_0004;
  localparam logic [31:0] BASE_AL  = 32'h1000_0000;

  typedef struct packed {
    logic [7:0]  rep;
    logic        rst;
    logic        trg;
    logic        wr;
    logic        en;
    logic [15:0] off;
    logic        ph;
    logic        dn;
    logic        wp;
  } vec_t;

  // center placement, 1 KB: window 64 words, 64 post words
  localparam vec_t TBL [15] = '{
    '{8'd1,  1'b0,1'b0,1'b1, 1'b1,16'd0,  1'b0,1'b0,1'b0}, // R2 first write
    '{8'd1,  1'b0,1'b0,1'b0, 1'b0,16'd1,  1'b0,1'b0,1'b0}, // R2 idle
    '{8'd62, 1'b0,1'b0,1'b1, 1'b1,16'd62, 1'b0,1'b0,1'b0}, // R2 fill
    '{8'd1,  1'b0,1'b0,1'b1, 1'b1,16'd63, 1'b0,1'b0,1'b0}, // R4 last slot
    '{8'd1,  1'b0,1'b0,1'b0, 1'b0,16'd0,  1'b0,1'b0,1'b1}, // R4 wrapped
    '{8'd5,  1'b0,1'b0,1'b1, 1'b1,16'd4,  1'b0,1'b0,1'b1}, // R2 after wrap
    '{8'd1,  1'b0,1'b1,1'b1, 1'b1,16'd5,  1'b0,1'b0,1'b1}, // R5 trig+write
    '{8'd1,  1'b0,1'b0,1'b0, 1'b0,16'd6,  1'b1,1'b0,1'b1}, // R5 post
    '{8'd1,  1'b0,1'b1,1'b1, 1'b1,16'd6,  1'b1,1'b0,1'b1}, // R7 late trig
    '{8'd62, 1'b0,1'b0,1'b1, 1'b1,16'd68, 1'b1,1'b0,1'b1}, // R6 fill
    '{8'd1,  1'b0,1'b0,1'b1, 1'b1,16'd69, 1'b1,1'b0,1'b1}, // R6 last post
    '{8'd1,  1'b0,1'b0,1'b1, 1'b0,16'd0,  1'b1,1'b1,1'b1}, // R6 done
    '{8'd1,  1'b0,1'b1,1'b1, 1'b0,16'd0,  1'b1,1'b1,1'b1}, // R7 trig after done
    '{8'd1,  1'b1,1'b0,1'b1, 1'b0,16'd0,  1'b1,1'b1,1'b1}, // R9 restart cycle
    '{8'd1,  1'b0,1'b0,1'b1, 1'b1,16'd0,  1'b0,1'b0,1'b0}  // R9 back at base
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              restart, trig, wr_req;
  logic [ADDR_W-1:0] cfg_base;
  logic [SIZE_W-1:0] cfg_size_kb;
  logic [1:0]        cfg_pos;
  logic              wr_en, phase, done, wrapped;
  logic [ADDR_W-1:0] wr_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trace_capture_ctl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_base(cfg_base),
    .cfg_size_kb(cfg_size_kb), .cfg_pos(cfg_pos), .wr_req(wr_req), .trig(trig),
    .wr_en(wr_en), .wr_addr(wr_addr), .phase(phase), .done(done), .wrapped(wrapped)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic t, input logic w);
    @(negedge clk);
    restart = r; trig = t; wr_req = w;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; trig = 1'b0; wr_req = 1'b0;
    cfg_base = BASE_RAW; cfg_size_kb = 4'd1; cfg_pos = 2'd1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset phase", phase, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset wrapped", wrapped, 0);
    chk("R1 reset wr_en", wr_en, 0);
    chk("R8 reset addr aligned", wr_addr, BASE_AL);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table, center placement
    for (int i = 0; i < 15; i++) begin
      for (int k = 0; k < int'(TBL[i].rep); k++) begin
        drive(TBL[i].rst, TBL[i].trg, TBL[i].wr);
        if (k == int'(TBL[i].rep) - 1) begin
          chk($sformatf("R2 table %0d wr_en", i), wr_en, TBL[i].en);
          if (TBL[i].en)
            chk($sformatf("R8 table %0d addr", i), wr_addr, BASE_AL + 32'(TBL[i].off) * 8);
          chk($sformatf("R5 table %0d phase", i), phase, TBL[i].ph);
          chk($sformatf("R6 table %0d done", i), done, TBL[i].dn);
          chk($sformatf("R4 table %0d wrapped", i), wrapped, TBL[i].wp);
        end
      end
    end

    // R3: begin placement drops pre data, then 128 post writes
    cfg_pos = 2'd0;
    drive(1, 0, 0);
    for (int j = 0; j < 3; j++) begin
      drive(0, 0, 1);
      chk("R3 pre write dropped", wr_en, 0);
    end
    drive(0, 1, 0);
    chk("R3 still pre at trig", phase, 0);
    for (int j = 0; j < 128; j++) begin
      drive(0, 0, 1);
      chk("R6 begin post wr_en", wr_en, 1);
      chk("R6 begin post addr", wr_addr, BASE_AL + 32'(j) * 8);
    end
    drive(0, 0, 1);
    chk("R6 begin stop wr_en", wr_en, 0);
    chk("R6 begin done", done, 1);
    drive(0, 1, 1);
    chk("R7 trig after done", wr_en, 0);

    // R2/R4/R6: end placement, full window then instant done
    cfg_pos = 2'd2;
    drive(1, 0, 0);
    for (int j = 0; j < 130; j++) begin
      drive(0, 0, 1);
      chk("R2 end addr", wr_addr, BASE_AL + 32'(j % 128) * 8);
      chk("R4 end wrap timing", wrapped, (j >= 128) ? 1 : 0);
    end
    drive(0, 0, 0);
    chk("R4 end wrapped", wrapped, 1);
    drive(0, 1, 0);
    drive(0, 0, 1);
    chk("R6 end done at trig", done, 1);
    chk("R6 end no write", wr_en, 0);
    chk("R5 end phase", phase, 1);

    // R2: code 3 behaves as end
    cfg_pos = 2'd3;
    drive(1, 0, 0);
    drive(0, 0, 1);
    chk("R2 code3 pre write", wr_en, 1);
    drive(0, 1, 0);
    drive(0, 0, 0);
    chk("R2 code3 done", done, 1);

    // R9: restart in the middle of post phase
    cfg_pos = 2'd1;
    drive(1, 0, 0);
    drive(0, 1, 0);
    drive(0, 0, 1);
    chk("R9 mid post phase", phase, 1);
    chk("R9 mid post addr", wr_addr, BASE_AL);
    drive(1, 0, 1);
    chk("R9 restart blocks write", wr_en, 0);
    drive(0, 0, 1);
    chk("R9 back pre", phase, 0);
    chk("R9 back base", wr_addr, BASE_AL);
    chk("R9 wrapped clear", wrapped, 0);

    // R2: 2 KB center, window of 128 words
    cfg_size_kb = 4'd2;
    drive(1, 0, 0);
    for (int j = 0; j < 128; j++) begin
      drive(0, 0, 1);
      chk("R2 2KB center addr", wr_addr, BASE_AL + 32'(j) * 8);
    end
    drive(0, 0, 1);
    chk("R2 2KB wrap to base", wr_addr, BASE_AL);
    chk("R4 2KB wrapped", wrapped, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule